// File: doc/BRIEF.md
# Converter Interrupt Flag and Vector Unit

This block holds two interrupt flags for each channel of a multi-channel converter. The first is a done flag, set when a fresh result lands in that channel's result register. The second is an overrun flag, set when a result lands before the previous one was read. The block merges all enabled pending flags into one interrupt request and one vector number. A handler reads the vector to find the source to service.

Each flag has its own enable input, and a global enable gates the request line. The converter datapath drives the result-write and result-read strobes. Software reaches the flags through per-flag set and clear strobes. A vector-access strobe stands for software touching the vector register, and that access changes nothing. The outputs follow the flags combinationally, and the flags are registered.

Top module: `adc_irq_vec`

## Requirements
- R1: After reset every done flag, overrun flag and unread mark is zero, so `irq_o` is 0 and `vec_o` is 0.
- R2: A pulse on `res_wr_i[n]` sets done flag n on the next clock edge.
- R3: `irq_o` is high exactly when `gie_i` is high and at least one flag is set with its own enable (`done_ie_i[n]` or `ovf_ie_i[n]`) high.
- R4: The overrun flag of channel n is set when `res_wr_i[n]` arrives while a previous result of that channel is unread and `res_rd_i[n]` is low in that cycle. A write and a read of the same channel in one cycle leave the done flag set and record no overrun.
- R5: `vec_o` is 0 with nothing enabled pending. It is 2 if any overrun flag is pending with its enable high. Otherwise it is 4 + 2*n for the lowest-numbered channel n whose done flag is pending and enabled. Flags whose enable is low, and `gie_i`, do not change `vec_o`.
- R6: A done flag clears on `res_rd_i[n]` or `done_clr_i[n]`. An overrun flag clears only on `ovf_clr_i[n]`, and a result read leaves it set.
- R7: A pulse on `vec_rd_i` changes no flag.
- R8: `done_set_i[n]` and `ovf_set_i[n]` set their flag. When a set and a clear hit the same flag in one cycle, the set wins.
- R9: When the highest-priority source is cleared, the next enabled pending source takes over `vec_o` and keeps `irq_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_wr_i | input | NUM_CH | Result written into channel result register |
| res_rd_i | input | NUM_CH | Channel result register read |
| done_set_i | input | NUM_CH | Software set of done flag |
| done_clr_i | input | NUM_CH | Software clear of done flag |
| ovf_set_i | input | NUM_CH | Software set of overrun flag |
| ovf_clr_i | input | NUM_CH | Software clear of overrun flag |
| done_ie_i | input | NUM_CH | Done flag enables |
| ovf_ie_i | input | NUM_CH | Overrun flag enables |
| gie_i | input | 1 | Global interrupt enable |
| vec_rd_i | input | 1 | Vector register access strobe |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | VEC_W | Prioritized vector number |

## Verification
The hardest case to reach is a lower-priority source that sits hidden under a pending overrun or a lower-numbered done flag. It has to surface at the right moment once the higher source is cleared. The pseudo-random sweep keeps strobe density low so that several flags stay pending together. It also flips the enables every cycle, which exposes hidden flags and then masks them again. Directed sequences cover same-cycle write plus read, same-cycle set plus clear, and read-without-clear of an overrun, and a bench model checks every cycle.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int unsigned VEC_NONE = 0;
  localparam int unsigned VEC_OVF  = 2;
  localparam int unsigned VEC_BASE = 4;

  function automatic int unsigned vec_width(input int unsigned n_ch);
    return $clog2(VEC_BASE + 2 * n_ch);
  endfunction
endpackage

// File: rtl/adc_irq_chan.sv
module adc_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic res_wr_i,
  input  logic res_rd_i,
  input  logic done_set_i,
  input  logic done_clr_i,
  input  logic ovf_set_i,
  input  logic ovf_clr_i,
  input  logic vec_rd_i,
  output logic done_o,
  output logic ovf_o
);
  logic done_q, ovf_q, unread_q;
  logic done_d, ovf_d, unread_d, late_wr;

  // overrun only when the previous result is not consumed in the same cycle
  assign late_wr  = res_wr_i & unread_q & ~res_rd_i;
  assign done_d   = res_wr_i | done_set_i | (done_q & ~res_rd_i & ~done_clr_i);
  assign ovf_d    = late_wr | ovf_set_i | (ovf_q & ~ovf_clr_i);
  assign unread_d = res_wr_i | (unread_q & ~res_rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      unread_q <= 1'b0;
    end else begin
      done_q   <= done_d;
      ovf_q    <= ovf_d;
      unread_q <= unread_d;
    end
  end

  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  AST_DONE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_wr_i |=> done_q); // R2
  AST_OVF_ON_LATE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_wr_i && unread_q && !res_rd_i) |=> ovf_q); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q); // R6
  AST_DONE_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_set_i && done_clr_i) |=> done_q); // R8
  AST_VEC_ACCESS_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && !res_wr_i && !res_rd_i && !done_set_i && !done_clr_i
     && !ovf_set_i && !ovf_clr_i) |=> ($stable(done_q) && $stable(ovf_q))); // R7
endmodule

// File: rtl/adc_irq_prio.sv
module adc_irq_prio
  import adc_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned VEC_W = vec_width(NUM_CH)
) (
  input  logic [NUM_CH-1:0] done_req_i,
  input  logic [NUM_CH-1:0] ovf_req_i,
  output logic              any_o,
  output logic [VEC_W-1:0]  vec_o
);
  always_comb begin
    vec_o = VEC_W'(VEC_NONE);
    // scan downward so the lowest channel is the last assignment
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (done_req_i[i]) vec_o = VEC_W'(VEC_BASE + 2 * i);
    end
    if (|ovf_req_i) vec_o = VEC_W'(VEC_OVF);
  end

  assign any_o = |done_req_i | |ovf_req_i;

  always_comb begin
    AST_VEC_EVEN: assert (vec_o[0] == 1'b0); // R5
    AST_OVF_FIRST: assert (!(|ovf_req_i) || vec_o == VEC_W'(VEC_OVF)); // R5
  end
endmodule

// File: rtl/adc_irq_vec.sv
module adc_irq_vec
  import adc_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned VEC_W = vec_width(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] res_wr_i,
  input  logic [NUM_CH-1:0] res_rd_i,
  input  logic [NUM_CH-1:0] done_set_i,
  input  logic [NUM_CH-1:0] done_clr_i,
  input  logic [NUM_CH-1:0] ovf_set_i,
  input  logic [NUM_CH-1:0] ovf_clr_i,
  input  logic [NUM_CH-1:0] done_ie_i,
  input  logic [NUM_CH-1:0] ovf_ie_i,
  input  logic              gie_i,
  input  logic              vec_rd_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NUM_CH-1:0] done_q, ovf_q;
  logic              any_req;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    adc_irq_chan i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .res_wr_i   (res_wr_i[g]),
      .res_rd_i   (res_rd_i[g]),
      .done_set_i (done_set_i[g]),
      .done_clr_i (done_clr_i[g]),
      .ovf_set_i  (ovf_set_i[g]),
      .ovf_clr_i  (ovf_clr_i[g]),
      .vec_rd_i   (vec_rd_i),
      .done_o     (done_q[g]),
      .ovf_o      (ovf_q[g])
    );
  end

  adc_irq_prio #(.NUM_CH(NUM_CH)) i_prio (
    .done_req_i (done_q & done_ie_i),
    .ovf_req_i  (ovf_q & ovf_ie_i),
    .any_o      (any_req),
    .vec_o      (vec_o)
  );

  assign irq_o = gie_i & any_req;

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_i); // R3
  AST_IRQ_ON_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && vec_o != '0) |-> irq_o); // R9
  AST_RESET_CLEAN: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (done_q == '0 && ovf_q == '0)); // R1
endmodule

// File: tb/test_adc_irq_vec.sv
module test_adc_irq_vec;
  localparam int N = 4;
  localparam int VW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] wr, rd, dset, dclr, oset, oclr, die, oie;
  logic gie, vrd, irq;
  logic [VW-1:0] vec;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_done = '0, m_ovf = '0, m_unr = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  bit done_flag = 0;

  always #4 clk = ~clk;

  adc_irq_vec #(.NUM_CH(N)) i_adc_irq_vec (
    .clk_i(clk), .rst_ni(rst_n), .res_wr_i(wr), .res_rd_i(rd),
    .done_set_i(dset), .done_clr_i(dclr), .ovf_set_i(oset), .ovf_clr_i(oclr),
    .done_ie_i(die), .ovf_ie_i(oie), .gie_i(gie), .vec_rd_i(vrd),
    .irq_o(irq), .vec_o(vec));

  function automatic int exp_vec();
    if (|(m_ovf & oie)) return 2;
    for (int i = 0; i < N; i++) if (m_done[i] & die[i]) return 4 + 2 * i;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_model(input string req);
    chk({req, " vec"}, int'(vec), exp_vec());
    chk({req, " irq"}, int'(irq), int'(gie && exp_vec() != 0));
  endtask

  task automatic idle();
    wr = '0; rd = '0; dset = '0; dclr = '0; oset = '0; oclr = '0; vrd = 1'b0;
  endtask

  // apply held inputs for one clock, advance model, compare
  task automatic step(input string req);
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) begin
      logic nd, no, nu;
      nd = wr[i] | dset[i] | (m_done[i] & ~rd[i] & ~dclr[i]);
      no = (wr[i] & m_unr[i] & ~rd[i]) | oset[i] | (m_ovf[i] & ~oclr[i]);
      nu = wr[i] | (m_unr[i] & ~rd[i]);
      m_done[i] = nd; m_ovf[i] = no; m_unr[i] = nu;
    end
    @(negedge clk);
    idle();
    #1 check_model(req);
  endtask

  initial begin
    idle(); die = '1; oie = '1; gie = 1'b1;
    #20 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 vec", int'(vec), 0);
    chk("R1 irq", int'(irq), 0);
    // R2: write channel 2
    wr = 4'b0100; step("R2");
    chk("R2 vec", int'(vec), 8);
    // R3: global enable masks request but not vector
    gie = 1'b0; #1;
    chk("R3 irq", int'(irq), 0);
    chk("R5 vec gie-indep", int'(vec), 8);
    gie = 1'b1;
    // R4: second write unread -> overrun
    wr = 4'b0100; step("R4");
    chk("R4 vec", int'(vec), 2);
    // R7: vector access touches nothing
    for (int k = 0; k < 3; k++) begin vrd = 1'b1; step("R7"); end
    chk("R7 vec", int'(vec), 2);
    // R6: read clears done but not overrun
    rd = 4'b0100; step("R6");
    oie = '0; #1;
    chk("R6 done cleared", int'(vec), 0);
    oie = '1; #1;
    chk("R6 ovf kept", int'(vec), 2);
    oclr = 4'b0100; step("R6");
    chk("R6 ovf cleared", int'(vec), 0);
    // R4: write+read same cycle -> done set, no overrun
    wr = 4'b0010; step("R4");
    wr = 4'b0010; rd = 4'b0010; step("R4");
    chk("R4 same-cycle", int'(vec), 6);
    rd = 4'b0010; step("R4");
    // R5/R9 priority among channels
    wr = 4'b1001; step("R5");
    die = 4'b1000; #1;
    chk("R5 masked low", int'(vec), 10);
    die = '1; #1;
    chk("R5 lowest wins", int'(vec), 4);
    dclr = 4'b0001; step("R9");
    chk("R9 next source", int'(vec), 10);
    chk("R9 irq", int'(irq), 1);
    dclr = 4'b1000; step("R9");
    // R8: set wins over clear
    dset = 4'b0100; dclr = 4'b0100; step("R8");
    chk("R8 done set wins", int'(vec), 8);
    oset = 4'b1000; oclr = 4'b1000; step("R8");
    chk("R8 ovf set wins", int'(vec), 2);
    oclr = 4'b1000; dclr = 4'b0100; step("R8");
    chk("R8 cleared", int'(vec), 0);
    // pseudo-random sweep against the model
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      r = lfsr;
      wr = r[3:0] & r[7:4];
      rd = r[11:8] & r[15:12];
      dset = r[19:16] & r[23:20] & r[27:24];
      dclr = r[23:20] & r[31:28] & r[11:8];
      oset = r[3:0] & r[19:16] & r[27:24] & r[31:28];
      oclr = r[15:12] & r[7:4] & r[27:24];
      vrd = r[5];
      die = r[27:24] | r[13:10];
      oie = r[31:28] & r[9:6];
      gie = r[14] | r[22];
      step("R5 sweep");
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      die = lfsr[3:0]; oie = lfsr[7:4]; gie = lfsr[8]; #1;
      check_model("R3 sweep");
    end
    done_flag = 1;
  end

  initial begin
    fork
      begin wait (done_flag); end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule